// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block is the digital sequencer placed in front of a multi-channel analog-to-digital converter. Software configures it with a last-channel code, a reference select and a decimation select, plus a mask of the pins that are wired as analog inputs. When a start condition occurs, the controller steps through a range of channel codes and skips any channel whose pins are not enabled. For each channel it keeps, it issues one conversion request to the converter. It also offers an extra single conversion that can be queued at any time. That conversion runs once the current sequence has finished, or at once when nothing is running.

Each converter result comes back as a signed two's complement word. The controller forwards it with its channel number as a one-cycle DMA request and sets an end-of-conversion flag, which software clears by reading the high result byte. The start condition is picked by a 2-bit select: an external pin edge, a free-running back-to-back mode, a timer event, or a software start bit.

Top module: `adc_seq_ctrl`

## Requirements
- R1: With a last-channel code L below 8, a sequence converts the channels 0 through L in ascending order, each one whose analog-enable bit is set.
- R2: With L from 8 to 12, a sequence covers the codes 8 through L in ascending order. Code 8+k (k = 0..3) is the differential pair of pins 2k and 2k+1 and is converted only when both of those mask bits are set.
- R3: Codes 12 to 15 (ground, internal reference, temperature, supply/3) use no pins and are never skipped. With L from 13 to 15, a sequence is exactly one conversion of channel L.
- R4: Channel codes 0 to 7 map to pins 0 to 7. A channel in that range whose mask bit (bit n for channel n) is clear is skipped without a request. A sequence whose channels are all skipped ends with no request.
- R5: The start select is coded as 00 for a rising edge on the external pin (seen through a two-flop synchronizer), 01 for free-running (a new sequence begins whenever the controller is idle), 10 for a timer event pulse, and 11 for the software start bit.
- R6: A software start write sets the start bit only when the start select is 11 and the controller is not busy. The start bit clears when its sequence completes.
- R7: Pin edges and timer events that arrive while the controller is busy are dropped.
- R8: A write to the extra-conversion register (channel, reference, decimation) queues one conversion that ignores the pin mask. It runs after any running sequence has finished, or right away when the controller is idle.
- R9: The reference and decimation codes on every request of a sequence are those latched at its start. Writes to the sequence register while a conversion is in progress are ignored.
- R10: A conversion request is a one-cycle pulse. Channel, reference and decimation stay unchanged until the converter's done pulse.
- R11: Each done pulse produces, one cycle later, a one-cycle DMA request carrying the signed result and the channel number, and sets the end-of-conversion flag.
- R12: A read strobe on the high result byte clears the end-of-conversion flag.
- R13: After reset, the controller is idle with no request, no DMA request, the flag clear and the start bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_wr | input | 1 | Write strobe for the sequence register |
| seq_last | input | 4 | Last-channel code |
| seq_ref | input | 2 | Reference select for the sequence |
| seq_dec | input | 2 | Decimation select for the sequence |
| pin_en | input | 8 | Analog-enable mask, bit n for pin n |
| trig_sel | input | 2 | Start select |
| sw_start_wr | input | 1 | Write strobe setting the software start bit |
| ext_pin | input | 1 | Asynchronous external start pin |
| timer_evt | input | 1 | Timer compare event pulse |
| xtra_wr | input | 1 | Write strobe for the extra conversion |
| xtra_ch | input | 4 | Extra conversion channel |
| xtra_ref | input | 2 | Extra conversion reference select |
| xtra_dec | input | 2 | Extra conversion decimation select |
| rd_hi | input | 1 | Read strobe of the high result byte |
| conv_done | input | 1 | Converter done pulse |
| conv_result | input | 14 | Signed converter result |
| conv_req | output | 1 | Conversion request pulse |
| conv_ch | output | 4 | Channel of the current request |
| conv_ref | output | 2 | Reference of the current request |
| conv_dec | output | 2 | Decimation of the current request |
| dma_req | output | 1 | One-cycle DMA request |
| dma_data | output | 14 | Result carried with the DMA request |
| dma_ch | output | 4 | Channel carried with the DMA request |
| eoc | output | 1 | End-of-conversion flag |
| sw_start | output | 1 | Software start bit |
| busy | output | 1 | Sequence or extra conversion running or queued |

## Verification
The assertions assume that the converter answers only an outstanding request, with a single-cycle done pulse. They also assume that the analog-enable mask does not change while a sequence is scanning. The bench's converter model keeps to both: it returns exactly one done pulse a fixed number of cycles after each request and never raises one at any other time. The driver changes the mask only between sequences, after the controller has reported not busy. The bench also issues the timer pulses and extra-register writes that fall during a running sequence, so the dropped-trigger and queued-conversion paths are exercised inside those same assumptions.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CH_W  = 4;
  localparam int REF_W = 2;
  localparam int DEC_W = 2;
  localparam int NPIN  = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_SCAN = 2'b01,
    ST_WAIT = 2'b10
  } seq_state_e;

  typedef enum logic [1:0] {
    TRG_PIN   = 2'b00,
    TRG_CONT  = 2'b01,
    TRG_TIMER = 2'b10,
    TRG_SW    = 2'b11
  } trig_sel_e;

  // Single-ended codes need their own pin, pair codes need both pins,
  // internal sources need none.
  function automatic logic chan_usable(input logic [CH_W-1:0] ch,
                                       input logic [NPIN-1:0] en);
    logic ok;
    if (ch < 4'd8)       ok = en[ch[2:0]];
    else if (ch < 4'd12) ok = en[{ch[1:0], 1'b0}] & en[{ch[1:0], 1'b1}];
    else                 ok = 1'b1;
    return ok;
  endfunction
endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_sn,
  input  logic       ext_pin,
  input  logic       timer_evt,
  input  logic       sw_bit,
  input  logic [1:0] trig_sel,
  input  logic       accept,
  output logic       start_evt
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;
  logic                   pin_rise;
  logic                   cond;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], ext_pin};
    prev_d = sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign pin_rise = sync_q[SYNC_STAGES-1] & ~prev_q;

  always_comb begin
    case (trig_sel)
      TRG_PIN:   cond = pin_rise;
      TRG_CONT:  cond = 1'b1;
      TRG_TIMER: cond = timer_evt;
      default:   cond = sw_bit;
    endcase
    start_evt = accept & cond;
  end
endmodule

// File: rtl/adc_seq_bounds.sv
module adc_seq_bounds
  import adc_seq_pkg::*;
(
  input  logic [CH_W-1:0] last_ch,
  output logic [CH_W-1:0] first_ch,
  output logic [CH_W-1:0] final_ch
);
  always_comb begin
    final_ch = last_ch;
    if (last_ch < 4'd8)       first_ch = '0;
    else if (last_ch < 4'd13) first_ch = 4'd8;
    else                      first_ch = last_ch;
  end
endmodule

// File: rtl/adc_result_stage.sv
module adc_result_stage
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 14
) (
  input  logic                    clk,
  input  logic                    rst_sn,
  input  logic                    take,
  input  logic signed [RES_W-1:0] result,
  input  logic [CH_W-1:0]         ch,
  input  logic                    rd_hi,
  output logic                    dma_req,
  output logic signed [RES_W-1:0] dma_data,
  output logic [CH_W-1:0]         dma_ch,
  output logic                    eoc
);
  logic                    req_q, req_d;
  logic signed [RES_W-1:0] data_q, data_d;
  logic [CH_W-1:0]         ch_q, ch_d;
  logic                    eoc_q, eoc_d;

  always_comb begin
    req_d  = take;
    data_d = data_q;
    ch_d   = ch_q;
    eoc_d  = eoc_q;
    if (rd_hi) eoc_d = 1'b0;
    if (take) begin
      data_d = result;
      ch_d   = ch;
      eoc_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      req_q  <= 1'b0;
      data_q <= '0;
      ch_q   <= '0;
      eoc_q  <= 1'b0;
    end else begin
      req_q <= req_d;
      eoc_q <= eoc_d;
      if (take) begin
        data_q <= data_d;
        ch_q   <= ch_d;
      end
    end
  end

  assign dma_req  = req_q;
  assign dma_data = data_q;
  assign dma_ch   = ch_q;
  assign eoc      = eoc_q;

  // R11: a DMA request always comes with the flag raised
  p_dma_flag_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    dma_req |-> eoc);
  // R11: the DMA request lasts a single cycle
  p_dma_pulse_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    dma_req |=> !dma_req);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W       = 14,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    seq_wr,
  input  logic [3:0]              seq_last,
  input  logic [1:0]              seq_ref,
  input  logic [1:0]              seq_dec,
  input  logic [7:0]              pin_en,
  input  logic [1:0]              trig_sel,
  input  logic                    sw_start_wr,
  input  logic                    ext_pin,
  input  logic                    timer_evt,
  input  logic                    xtra_wr,
  input  logic [3:0]              xtra_ch,
  input  logic [1:0]              xtra_ref,
  input  logic [1:0]              xtra_dec,
  input  logic                    rd_hi,
  input  logic                    conv_done,
  input  logic signed [RES_W-1:0] conv_result,
  output logic                    conv_req,
  output logic [3:0]              conv_ch,
  output logic [1:0]              conv_ref,
  output logic [1:0]              conv_dec,
  output logic                    dma_req,
  output logic signed [RES_W-1:0] dma_data,
  output logic [3:0]              dma_ch,
  output logic                    eoc,
  output logic                    sw_start,
  output logic                    busy
);
  logic rst_sn;

  adc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  // ---- state -----------------------------------------------------------
  seq_state_e       state_q, state_d;
  logic [CH_W-1:0]  cur_q, cur_d;
  logic [CH_W-1:0]  end_q, end_d;
  logic [REF_W-1:0] act_ref_q, act_ref_d;
  logic [DEC_W-1:0] act_dec_q, act_dec_d;
  logic             xmode_q, xmode_d;
  logic [CH_W-1:0]  sq_last_q, sq_last_d;
  logic [REF_W-1:0] sq_ref_q, sq_ref_d;
  logic [DEC_W-1:0] sq_dec_q, sq_dec_d;
  logic             xp_q, xp_d;
  logic [CH_W-1:0]  xp_ch_q, xp_ch_d;
  logic [REF_W-1:0] xp_ref_q, xp_ref_d;
  logic [DEC_W-1:0] xp_dec_q, xp_dec_d;
  logic             st_bit_q, st_bit_d;
  logic             req_q, req_d;

  logic             active;
  logic             accept;
  logic             start_evt;
  logic             usable;
  logic             finish;
  logic             take;
  logic [CH_W-1:0]  first_ch, final_ch;

  assign active = (state_q != ST_IDLE);
  assign accept = !active && !xp_q;
  assign take   = conv_done && (state_q == ST_WAIT);

  adc_trig_sel #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk(clk), .rst_sn(rst_sn), .ext_pin(ext_pin), .timer_evt(timer_evt),
    .sw_bit(st_bit_q), .trig_sel(trig_sel), .accept(accept),
    .start_evt(start_evt)
  );

  adc_seq_bounds u_bounds (
    .last_ch(sq_last_q), .first_ch(first_ch), .final_ch(final_ch)
  );

  assign usable = xmode_q | chan_usable(cur_q, pin_en);

  // ---- next state ------------------------------------------------------
  always_comb begin
    state_d   = state_q;
    cur_d     = cur_q;
    end_d     = end_q;
    act_ref_d = act_ref_q;
    act_dec_d = act_dec_q;
    xmode_d   = xmode_q;
    sq_last_d = sq_last_q;
    sq_ref_d  = sq_ref_q;
    sq_dec_d  = sq_dec_q;
    xp_d      = xp_q;
    xp_ch_d   = xp_ch_q;
    xp_ref_d  = xp_ref_q;
    xp_dec_d  = xp_dec_q;
    st_bit_d  = st_bit_q;
    req_d     = 1'b0;
    finish    = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (xp_q) begin
          state_d   = ST_SCAN;
          cur_d     = xp_ch_q;
          end_d     = xp_ch_q;
          act_ref_d = xp_ref_q;
          act_dec_d = xp_dec_q;
          xmode_d   = 1'b1;
          xp_d      = 1'b0;
        end else if (start_evt) begin
          state_d   = ST_SCAN;
          cur_d     = first_ch;
          end_d     = final_ch;
          act_ref_d = sq_ref_q;
          act_dec_d = sq_dec_q;
          xmode_d   = 1'b0;
        end
      end
      ST_SCAN: begin
        if (usable) begin
          req_d   = 1'b1;
          state_d = ST_WAIT;
        end else if (cur_q == end_q) begin
          finish  = 1'b1;
        end else begin
          cur_d   = cur_q + 4'd1;
        end
      end
      ST_WAIT: begin
        if (conv_done) begin
          if (cur_q == end_q) begin
            finish  = 1'b1;
          end else begin
            cur_d   = cur_q + 4'd1;
            state_d = ST_SCAN;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (finish) begin
      state_d = ST_IDLE;
      if (!xmode_q) st_bit_d = 1'b0;
    end

    if (seq_wr && !active) begin
      sq_last_d = seq_last;
      sq_ref_d  = seq_ref;
      sq_dec_d  = seq_dec;
    end

    if (xtra_wr) begin
      xp_d     = 1'b1;
      xp_ch_d  = xtra_ch;
      xp_ref_d = xtra_ref;
      xp_dec_d = xtra_dec;
    end

    if (sw_start_wr && !busy && (trig_sel == TRG_SW)) st_bit_d = 1'b1;
  end

  // ---- registers -------------------------------------------------------
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q   <= ST_IDLE;
      cur_q     <= '0;
      end_q     <= '0;
      act_ref_q <= '0;
      act_dec_q <= '0;
      xmode_q   <= 1'b0;
      sq_last_q <= '0;
      sq_ref_q  <= '0;
      sq_dec_q  <= '0;
      xp_q      <= 1'b0;
      xp_ch_q   <= '0;
      xp_ref_q  <= '0;
      xp_dec_q  <= '0;
      st_bit_q  <= 1'b0;
      req_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      cur_q    <= cur_d;
      xp_q     <= xp_d;
      st_bit_q <= st_bit_d;
      req_q    <= req_d;
      if (!active) begin
        end_q     <= end_d;
        act_ref_q <= act_ref_d;
        act_dec_q <= act_dec_d;
        xmode_q   <= xmode_d;
      end
      if (seq_wr && !active) begin
        sq_last_q <= sq_last_d;
        sq_ref_q  <= sq_ref_d;
        sq_dec_q  <= sq_dec_d;
      end
      if (xtra_wr) begin
        xp_ch_q  <= xp_ch_d;
        xp_ref_q <= xp_ref_d;
        xp_dec_q <= xp_dec_d;
      end
    end
  end

  adc_result_stage #(.RES_W(RES_W)) u_res (
    .clk(clk), .rst_sn(rst_sn), .take(take), .result(conv_result),
    .ch(cur_q), .rd_hi(rd_hi), .dma_req(dma_req), .dma_data(dma_data),
    .dma_ch(dma_ch), .eoc(eoc)
  );

  assign conv_req = req_q;
  assign conv_ch  = cur_q;
  assign conv_ref = act_ref_q;
  assign conv_dec = act_dec_q;
  assign sw_start = st_bit_q;
  assign busy     = active | xp_q;

  // ---- assertions ------------------------------------------------------
  // R10: request is a single-cycle pulse
  p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    conv_req |=> !conv_req);
  // R10: channel held while the converter works
  p_ch_hold_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_WAIT && $past(state_q == ST_WAIT)) |-> $stable(conv_ch));
  // R10: done pulses only answer an outstanding request (input assumption)
  p_done_waiting_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    conv_done |-> (state_q == ST_WAIT));
  // R9: reference and decimation frozen for the whole run
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (active && $past(active)) |-> ($stable(conv_ref) && $stable(conv_dec)));
  // R4: no sequence request for a disabled single-ended pin
  p_skip_masked_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (conv_req && !xmode_q && conv_ch < 4'd8) |-> pin_en[conv_ch[2:0]]);
endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
  localparam int RES_W = 14;
  localparam int LAT   = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic                    rst_n;
  logic                    seq_wr;
  logic [3:0]              seq_last;
  logic [1:0]              seq_ref, seq_dec;
  logic [7:0]              pin_en;
  logic [1:0]              trig_sel;
  logic                    sw_start_wr, ext_pin, timer_evt;
  logic                    xtra_wr;
  logic [3:0]              xtra_ch;
  logic [1:0]              xtra_ref, xtra_dec;
  logic                    rd_hi, conv_done;
  logic signed [RES_W-1:0] conv_result;
  logic                    conv_req, dma_req, eoc, sw_start, busy;
  logic [3:0]              conv_ch, dma_ch;
  logic [1:0]              conv_ref, conv_dec;
  logic signed [RES_W-1:0] dma_data;

  adc_seq_ctrl #(.RES_W(RES_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .seq_wr(seq_wr), .seq_last(seq_last),
    .seq_ref(seq_ref), .seq_dec(seq_dec), .pin_en(pin_en),
    .trig_sel(trig_sel), .sw_start_wr(sw_start_wr), .ext_pin(ext_pin),
    .timer_evt(timer_evt), .xtra_wr(xtra_wr), .xtra_ch(xtra_ch),
    .xtra_ref(xtra_ref), .xtra_dec(xtra_dec), .rd_hi(rd_hi),
    .conv_done(conv_done), .conv_result(conv_result), .conv_req(conv_req),
    .conv_ch(conv_ch), .conv_ref(conv_ref), .conv_dec(conv_dec),
    .dma_req(dma_req), .dma_data(dma_data), .dma_ch(dma_ch), .eoc(eoc),
    .sw_start(sw_start), .busy(busy)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int n_req  = 0;
  bit done_flag = 0;
  logic [7:0] exp_q[$];

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // Expected-item model taken from the requirements.
  function automatic bit model_usable(input int c, input logic [7:0] m);
    if (c < 8)  return m[c];
    if (c < 12) return m[2*(c-8)] && m[2*(c-8)+1];
    return 1'b1;
  endfunction

  task automatic push_seq(input int last, input logic [7:0] m,
                          input logic [1:0] r, input logic [1:0] d);
    int first = (last < 8) ? 0 : ((last < 13) ? 8 : last);
    for (int c = first; c <= last; c++)
      if (model_usable(c, m)) exp_q.push_back({c[3:0], r, d});
  endtask

  // ---- monitor and converter model --------------------------------------
  int                      resp_cnt = 0;
  logic [3:0]              resp_ch;
  logic signed [RES_W-1:0] resp_val, exp_val;
  logic [3:0]              exp_ch;
  int                      seed = 0;

  always @(negedge clk) begin
    conv_done = 1'b0;
    if (resp_cnt > 0) begin
      resp_cnt--;
      if (resp_cnt == 0) begin
        conv_done   = 1'b1;
        conv_result = resp_val;
        exp_val     = resp_val;
        exp_ch      = resp_ch;
      end
    end
    if (dma_req) begin
      // R11: DMA carries result and channel, flag set
      check(dma_data == exp_val, "R11 dma data", int'(dma_data), int'(exp_val));
      check(dma_ch == exp_ch, "R11 dma channel", dma_ch, exp_ch);
      check(eoc == 1'b1, "R11 eoc set", eoc, 1);
    end
    if (conv_req) begin
      logic [7:0] got;
      n_req++;
      got = {conv_ch, conv_ref, conv_dec};
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected request", got, 0);
      end else begin
        logic [7:0] want;
        want = exp_q.pop_front();
        check(got == want, "R1/R2/R3/R8/R9 request ch-ref-dec", got, want);
      end
      seed++;
      resp_ch  = conv_ch;
      resp_val = RES_W'(int'(conv_ch) * 517 - 3000 + seed * 13);
      resp_cnt = LAT;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_seq(input logic [3:0] l, input logic [1:0] r, input logic [1:0] d);
    seq_last = l; seq_ref = r; seq_dec = d; seq_wr = 1'b1;
    tick(1); seq_wr = 1'b0;
  endtask

  task automatic sw_go();
    sw_start_wr = 1'b1; tick(1); sw_start_wr = 1'b0;
  endtask

  task automatic wr_xtra(input logic [3:0] c, input logic [1:0] r, input logic [1:0] d);
    xtra_ch = c; xtra_ref = r; xtra_dec = d; xtra_wr = 1'b1;
    tick(1); xtra_wr = 1'b0;
  endtask

  task automatic wait_idle(input string rq);
    tick(6);
    while (busy) tick(1);
    tick(LAT + 4);
    check(exp_q.size() == 0, rq, exp_q.size(), 0);
  endtask

  task automatic run_sw(input int last, input logic [7:0] m,
                        input logic [1:0] r, input logic [1:0] d, input string rq);
    pin_en = m;
    wr_seq(4'(last), r, d);
    push_seq(last, m, r, d);
    sw_go();
    wait_idle(rq);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    int base;
    rst_n = 1'b0; seq_wr = 0; seq_last = 0; seq_ref = 0; seq_dec = 0;
    pin_en = 8'hFF; trig_sel = 2'b11; sw_start_wr = 0; ext_pin = 0;
    timer_evt = 0; xtra_wr = 0; xtra_ch = 0; xtra_ref = 0; xtra_dec = 0;
    rd_hi = 0; conv_done = 0; conv_result = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R13: reset state
    check(busy == 0, "R13 busy", busy, 0);
    check(eoc == 0, "R13 eoc", eoc, 0);
    check(conv_req == 0 && dma_req == 0, "R13 requests", conv_req, 0);
    check(sw_start == 0, "R13 start bit", sw_start, 0);

    // R1: full low range
    run_sw(5, 8'hFF, 2'd1, 2'd2, "R1 seq 0..5 drained");
    // R6: start bit cleared at end
    check(sw_start == 0, "R6 start bit cleared", sw_start, 0);
    // R12: read strobe clears the flag
    check(eoc == 1, "R12 eoc before read", eoc, 1);
    rd_hi = 1; tick(1); rd_hi = 0; tick(1);
    check(eoc == 0, "R12 eoc after read", eoc, 0);

    // R4: masked single-ended channels skipped
    run_sw(7, 8'b1010_0101, 2'd0, 2'd3, "R4 masked seq drained");
    // R2: differential pairs
    run_sw(10, 8'b1111_0011, 2'd2, 2'd1, "R2 pair seq drained");
    // R3: internal sources need no pins, single conversion above 12
    run_sw(12, 8'h00, 2'd3, 2'd0, "R3 seq to 12 drained");
    run_sw(14, 8'h00, 2'd1, 2'd1, "R3 single 14 drained");
    // R4: all skipped, no request, start bit still clears
    base = n_req;
    run_sw(3, 8'h00, 2'd0, 2'd0, "R4 empty seq drained");
    check(n_req == base, "R4 empty seq request count", n_req - base, 0);
    check(sw_start == 0 && busy == 0, "R6 empty seq end", sw_start, 0);

    // R9: seq register write while busy ignored
    pin_en = 8'hFF;
    wr_seq(4'd3, 2'd0, 2'd0);
    push_seq(3, 8'hFF, 2'd0, 2'd0);
    sw_go();
    tick(4);
    wr_seq(4'd1, 2'd3, 2'd3);
    wait_idle("R9 first run drained");
    push_seq(3, 8'hFF, 2'd0, 2'd0);
    sw_go();
    wait_idle("R9 old config kept");

    // R8: extra queued behind a running sequence
    wr_seq(4'd2, 2'd1, 2'd2);
    push_seq(2, 8'hFF, 2'd1, 2'd2);
    sw_go();
    tick(4);
    wr_xtra(4'd13, 2'd3, 2'd0);
    exp_q.push_back({4'd13, 2'd3, 2'd0});
    wait_idle("R8 extra after sequence");
    // R8: extra from idle ignores the mask
    pin_en = 8'h00;
    exp_q.push_back({4'd9, 2'd2, 2'd1});
    wr_xtra(4'd9, 2'd2, 2'd1);
    wait_idle("R8 extra from idle");

    // R6: software write ignored under another start select
    pin_en = 8'hFF;
    trig_sel = 2'b00;
    sw_go();
    tick(5);
    check(sw_start == 0, "R6 start bit ignored", sw_start, 0);
    check(busy == 0, "R6 no run", busy, 0);

    // R5: external pin edge
    wr_seq(4'd1, 2'd2, 2'd2);
    push_seq(1, 8'hFF, 2'd2, 2'd2);
    ext_pin = 1'b1;
    wait_idle("R5 pin edge run");
    ext_pin = 1'b0;
    tick(4);

    // R5/R7: timer trigger, second event while busy dropped
    trig_sel = 2'b10;
    wr_seq(4'd2, 2'd0, 2'd1);
    push_seq(2, 8'hFF, 2'd0, 2'd1);
    base = n_req;
    timer_evt = 1'b1; tick(1); timer_evt = 1'b0;
    tick(5);
    timer_evt = 1'b1; tick(1); timer_evt = 1'b0;
    wait_idle("R5 timer run");
    check(n_req - base == 3, "R7 busy timer dropped", n_req - base, 3);

    // R5: free-running, stopped by switching select mid run
    trig_sel = 2'b11;
    wr_seq(4'd1, 2'd3, 2'd1);
    push_seq(1, 8'hFF, 2'd3, 2'd1);
    push_seq(1, 8'hFF, 2'd3, 2'd1);
    base = n_req;
    trig_sel = 2'b01;
    while (n_req - base < 3) tick(1);
    trig_sel = 2'b11;
    wait_idle("R5 free-running drained");
    check(n_req - base == 4, "R5 free-running count", n_req - base, 4);

    tick(5);
    finish_run();
  end
endmodule